// File: doc/BRIEF.md
# Overlapped Translation and Physically Tagged Cache Lookup

This block is the front of a small data cache that starts the cache read before it knows the physical address. The lines are selected only by the bits of the virtual address that lie inside the page, and translation never changes those bits. The cache array can therefore be read in the same cycle that an external translation buffer looks up the page number. In the next cycle the stored tag is compared with the translated frame number. Every request ends in one of three ways: the word is returned from the cache, the word is fetched from memory and written into the line, or the requester is told that a full page-table translation is needed.

The requester presents a virtual address together with the frame number and hit flag from the translation buffer. A valid/ready handshake accepts one request at a time. Refills use a simple request/response memory port. The default configuration is 1024 direct-mapped lines of one 32-bit word each. It uses a 12-bit page offset, of which bits [11:2] form the line index and bits [1:0] select the byte, and a 20-bit physical frame number that serves as the tag.

Top module: `ptag_lookup`

## Requirements
- R1: Reset clears every line's valid bit: after reset, each lookup with a translation hit resolves as a memory fill. Reset also leaves req_ready=1, rsp_valid=0 and mem_req_valid=0.
- R2: The line index is req_vaddr[11:2]. The byte offset bits req_vaddr[1:0] have no effect on the outcome or on the returned word.
- R3: When the translation hits and the indexed line is valid with a tag equal to xlt_pfn, the cycle after acceptance shows rsp_valid=1, rsp_kind=0 (hit) and the stored word, with no memory request.
- R4: When the translation hits and the line is invalid or its tag differs, the block issues mem_req_valid with mem_req_addr = {xlt_pfn, req_vaddr[11:2], 2'b00}. This happens two cycles after acceptance, and no response is given before then.
- R5: When the translation misses (xlt_hit=0), the cycle after acceptance shows rsp_valid=1 and rsp_kind=2 (translate). No memory request is made and no line is changed.
- R6: In the cycle mem_rsp_valid is high, the block responds with rsp_kind=1 (fill) and rsp_data equal to mem_rsp_data. It also writes that word, the frame tag and a set valid bit into the line, so a repeat of the same lookup hits.
- R7: req_ready is low from the cycle after acceptance until the request resolves. The request fields are captured at acceptance, so input changes while busy have no effect.
- R8: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is sampled high.
- R9: The virtual page number bits req_vaddr[31:12] do not take part in the lookup: two virtual pages that map to the same frame hit the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| xlt_hit | input | 1 | Translation buffer hit for req_vaddr |
| xlt_pfn | input | 20 | Translated physical frame number |
| rsp_valid | output | 1 | Outcome present (one-cycle pulse) |
| rsp_kind | output | 2 | 0 hit, 1 fill, 2 translate |
| rsp_data | output | 32 | Returned word for hit and fill |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned physical address |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | 32 | Memory read word |

## Verification
A line whose valid bit or tag is wrong shows up at the ports on the next lookup of that index. The cycle after acceptance carries a hit where a memory request was due, or a memory request appears where a hit was due. A wrong stored word shows as a rsp_data mismatch in that same cycle. The sweeps visit every index with frame numbers that differ per line, so a stuck or aliased index bit turns one index's fill into another's false hit within one pass. A captured field that leaks from the live inputs shows as a wrong memory address two cycles after acceptance.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
   typedef enum logic [1:0] {
      RSP_HIT   = 2'd0,
      RSP_FILL  = 2'd1,
      RSP_XLATE = 2'd2
   } rsp_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOK  = 2'd1,
      ST_MREQ  = 2'd2,
      ST_MWAIT = 2'd3
   } lookup_state_e;
endpackage

// File: rtl/ptag_line_store.sv
module ptag_line_store #(
   parameter int IDX_W  = 10,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int LINES  = 1 << IDX_W;
   localparam int ENTRY_W = TAG_W + DATA_W;

   logic [ENTRY_W-1:0] body [LINES];
   logic [LINES-1:0]   vbit;
   logic [ENTRY_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) body[wr_idx] <= {wr_tag, wr_data};
      if (rd_en) rd_q <= body[rd_idx];
   end

   assign rd_tag  = rd_q[ENTRY_W-1:DATA_W];
   assign rd_data = rd_q[DATA_W-1:0];

   for (genvar g = 0; g < LINES; g++) begin : g_vbit
      always_ff @(posedge clk) begin
         if (!rst_n)                              vbit[g] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(g))   vbit[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_valid <= 1'b0;
      else if (rd_en) rd_valid <= vbit[rd_idx];
   end

   a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vbit[$past(wr_idx)]);

   a_r7_no_read_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));
endmodule

// File: rtl/ptag_ctrl.sv
module ptag_ctrl
   import ptag_pkg::*;
#(
   parameter int PFN_W      = 20,
   parameter int PAGE_OFF_W = 12,
   parameter int BYTE_OFF_W = 2,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = PAGE_OFF_W - BYTE_OFF_W,
   localparam int PA_W      = PFN_W + PAGE_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic              xlt_hit,
   input  logic [PFN_W-1:0]  xlt_pfn,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_valid,
   input  logic [PFN_W-1:0]  rd_tag,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [PFN_W-1:0]  wr_tag,
   output logic [DATA_W-1:0] wr_data
);
   lookup_state_e      st, st_nx;
   logic [IDX_W-1:0]   q_idx;
   logic [PFN_W-1:0]   q_pfn;
   logic               q_hit;
   logic               tag_match;

   assign req_ready = (st == ST_IDLE);
   assign rd_en     = req_valid && req_ready;
   assign rd_idx    = req_idx;
   assign tag_match = rd_valid && (rd_tag == q_pfn);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         q_idx <= '0;
         q_pfn <= '0;
         q_hit <= 1'b0;
      end else begin
         st <= st_nx;
         if (rd_en) begin
            q_idx <= req_idx;
            q_pfn <= xlt_pfn;
            q_hit <= xlt_hit;
         end
      end
   end

   always_comb begin
      st_nx     = st;
      rsp_valid = 1'b0;
      rsp_kind  = RSP_HIT;
      rsp_data  = '0;
      wr_en     = 1'b0;
      unique case (st)
         ST_IDLE:  if (req_valid) st_nx = ST_LOOK;
         ST_LOOK: begin
            if (!q_hit) begin
               rsp_valid = 1'b1;
               rsp_kind  = RSP_XLATE;
               st_nx     = ST_IDLE;
            end else if (tag_match) begin
               rsp_valid = 1'b1;
               rsp_kind  = RSP_HIT;
               rsp_data  = rd_data;
               st_nx     = ST_IDLE;
            end else begin
               st_nx = ST_MREQ;
            end
         end
         ST_MREQ:  if (mem_req_ready) st_nx = ST_MWAIT;
         ST_MWAIT: if (mem_rsp_valid) begin
            rsp_valid = 1'b1;
            rsp_kind  = RSP_FILL;
            rsp_data  = mem_rsp_data;
            wr_en     = 1'b1;
            st_nx     = ST_IDLE;
         end
         default:  st_nx = ST_IDLE;
      endcase
   end

   assign mem_req_valid = (st == ST_MREQ);
   assign mem_req_addr  = {q_pfn, q_idx, {BYTE_OFF_W{1'b0}}};
   assign wr_idx        = q_idx;
   assign wr_tag        = q_pfn;
   assign wr_data       = mem_rsp_data;

   a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r8_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r5_xlate_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RSP_XLATE) |-> (!mem_req_valid && !wr_en));

   a_r6_fill_with_mem_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RSP_FILL) |-> (mem_rsp_valid && rsp_data == mem_rsp_data));

   a_r3_hit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RSP_HIT) |=> (req_ready && !mem_req_valid));
endmodule

// File: rtl/ptag_lookup.sv
module ptag_lookup #(
   parameter int VA_W       = 32,
   parameter int PFN_W      = 20,
   parameter int PAGE_OFF_W = 12,
   parameter int BYTE_OFF_W = 2,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = PAGE_OFF_W - BYTE_OFF_W,
   localparam int PA_W      = PFN_W + PAGE_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              xlt_hit,
   input  logic [PFN_W-1:0]  xlt_pfn,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   if (PAGE_OFF_W <= BYTE_OFF_W) begin : g_bad_offset
      $error("page offset must be wider than the byte offset");
   end
   if (VA_W <= PAGE_OFF_W) begin : g_bad_va
      $error("virtual address must be wider than the page offset");
   end
   if (IDX_W > 14) begin : g_bad_depth
      $error("line index wider than 14 bits is not supported");
   end

   logic              rd_en, rd_valid, wr_en;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [PFN_W-1:0]  rd_tag, wr_tag;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              unused_vaddr_bits;

   assign unused_vaddr_bits = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BYTE_OFF_W-1:0]};

   ptag_ctrl #(
      .PFN_W(PFN_W), .PAGE_OFF_W(PAGE_OFF_W),
      .BYTE_OFF_W(BYTE_OFF_W), .DATA_W(DATA_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_idx(req_vaddr[PAGE_OFF_W-1:BYTE_OFF_W]),
      .xlt_hit(xlt_hit), .xlt_pfn(xlt_pfn),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_tag(rd_tag), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
   );

   ptag_line_store #(
      .IDX_W(IDX_W), .TAG_W(PFN_W), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_tag(rd_tag), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
   );

   a_r4_fill_addr_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> (mem_req_addr[BYTE_OFF_W-1:0] == '0));
endmodule

// File: tb/tb_ptag_lookup.sv
`timescale 1ns/1ps
module tb_ptag_lookup;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        xlt_hit = 1'b0;
   logic [19:0] xlt_pfn = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_kind;
   logic [31:0] rsp_data;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int nvec = 0;
   int nerr = 0;
   logic        sv_v [1024];
   logic [19:0] sv_t [1024];

   always #2.5 clk = ~clk;

   ptag_lookup dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .xlt_hit(xlt_hit), .xlt_pfn(xlt_pfn),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] pa);
      return pa * 32'h9E37_79B1 + 32'h0123_4567;
   endfunction

   task automatic check(input logic ok, input string rq, input logic [31:0] act,
                        input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 1024; k++) sv_v[k] = 1'b0;
      check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R1 rsp", 32'(rsp_valid), 32'd0);
      check(mem_req_valid == 1'b0, "R1 mreq", 32'(mem_req_valid), 32'd0);
   endtask

   // Called at a falling edge with the block idle.
   task automatic lookup(input logic [31:0] va, input logic th, input logic [19:0] pfn,
                         input string tag);
      int          idx;
      logic [1:0]  ek;
      logic [31:0] pa, ed;
      idx = int'(va[11:2]);
      pa  = {pfn, va[11:2], 2'b00};
      ed  = mem_word(pa);
      if (!th) ek = 2'd2;
      else if (sv_v[idx] && sv_t[idx] == pfn) ek = 2'd0;
      else ek = 2'd1;

      check(req_ready == 1'b1, {tag, " R7 idle ready"}, 32'(req_ready), 32'd1);
      req_vaddr = va; xlt_hit = th; xlt_pfn = pfn; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = ~va; xlt_pfn = ~pfn; xlt_hit = ~th;
      check(req_ready == 1'b0, {tag, " R7 busy"}, 32'(req_ready), 32'd0);
      if (ek != 2'd1) begin
         check(rsp_valid == 1'b1, {tag, " R3/R5 rsp_valid"}, 32'(rsp_valid), 32'd1);
         check(rsp_kind == ek, {tag, " R3/R5 kind"}, 32'(rsp_kind), 32'(ek));
         if (ek == 2'd0)
            check(rsp_data == ed, {tag, " R3 data"}, rsp_data, ed);
         check(mem_req_valid == 1'b0, {tag, " R5 no mem"}, 32'(mem_req_valid), 32'd0);
         @(negedge clk);
      end else begin
         check(rsp_valid == 1'b0, {tag, " R4 no early rsp"}, 32'(rsp_valid), 32'd0);
         @(negedge clk);
         check(mem_req_valid == 1'b1, {tag, " R4 mreq"}, 32'(mem_req_valid), 32'd1);
         check(mem_req_addr == pa, {tag, " R4 addr"}, mem_req_addr, pa);
         @(negedge clk);
         check(mem_req_valid == 1'b1 && mem_req_addr == pa, {tag, " R8 hold"},
               mem_req_addr, pa);
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         check(mem_req_valid == 1'b0, {tag, " R8 drop"}, 32'(mem_req_valid), 32'd0);
         check(rsp_valid == 1'b0, {tag, " R6 wait"}, 32'(rsp_valid), 32'd0);
         mem_rsp_valid = 1'b1; mem_rsp_data = ed;
         #1;
         check(rsp_valid == 1'b1 && rsp_kind == 2'd1, {tag, " R6 fill kind"},
               32'(rsp_kind), 32'd1);
         check(rsp_data == ed, {tag, " R6 fill data"}, rsp_data, ed);
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         sv_v[idx] = 1'b1;
         sv_t[idx] = pfn;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: every line empty, so each translated lookup fills
      for (int i = 0; i < 1024; i++)
         lookup({20'(i * 13), 10'(i), 2'(i)}, 1'b1, 20'(i * 7 + 3), "R1");
      // R2/R9: other page numbers and byte offsets, same frame -> hit
      for (int i = 0; i < 1024; i++)
         lookup({20'(i * 29 + 5), 10'(i), 2'(i + 1)}, 1'b1, 20'(i * 7 + 3), "R2 R9");
      // R4: new frame on even lines
      for (int i = 0; i < 1024; i += 2)
         lookup({20'(i), 10'(i), 2'b00}, 1'b1, 20'(i * 7 + 3) ^ 20'h80000, "R4");
      // R5: translation misses leave lines untouched
      for (int i = 0; i < 1024; i += 3)
         lookup({20'(i), 10'(i), 2'b11}, 1'b0, 20'(i * 7 + 3), "R5");
      // R6: re-lookup of refilled and untouched lines
      for (int i = 0; i < 1024; i++)
         lookup({20'(i + 1), 10'(i), 2'b10}, 1'b1,
                (i % 2 == 0) ? (20'(i * 7 + 3) ^ 20'h80000) : 20'(i * 7 + 3), "R6");
      // R1: a second reset empties the lines again
      do_reset();
      for (int i = 0; i < 16; i++)
         lookup({20'(i), 10'(i * 61), 2'b00}, 1'b1, 20'(i * 61 * 7 + 3), "R1 rereset");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule